// File: doc/BRIEF.md
# Four-Lane 7:1 Display Serializer

This block turns a 28-bit parallel pixel word into four serial data lanes and one clock lane. Everything runs in a single fast clock domain whose rate is seven times the pixel rate. The pixel clock arrives as an ordinary input. It is synchronised and examined for its active edge, and a select input chooses which edge of the pixel clock is active. Every detected active edge captures a word. The block then emits the word as four 7-bit slices, one bit per fast cycle and one slice per lane. Alongside the slices it emits a clock-lane pattern that is phase-locked to the frames.

Framing is self-timed. Once a first edge has started it, a new frame begins every seven fast cycles. Each frame carries the most recently captured word, so a missing or late pixel edge repeats the previous word. A disable input clears the block and holds every lane low. While it is asserted, pixel edges are ignored.

Top module: `lvds7_tx`

## Requirements
- R1: After reset all four data lanes and the clock lane are low, and they stay low until an active pixel edge is detected.
- R2: The pixel clock passes through two synchroniser flops and is compared with the previous synchronised sample. With edge_sel_i=0 the rising edge is active, and with edge_sel_i=1 the falling edge is active. When idle, the first serial bit appears on the outputs after the third rising clk_i edge that follows the pixel-clock transition.
- R3: Lane k (bit k of lane_o) carries word bits 7k+6 down to 7k, most significant bit first, one bit per clk_i cycle.
- R4: Once running, frames follow back to back with a period of exactly seven clk_i cycles.
- R5: At each frame start the lanes carry the word captured at the latest active edge. If an active edge is detected in the same cycle as a frame boundary, the word presented in that cycle is the one sent.
- R6: When no active edge has arrived since the previous frame, the previous word is sent again unchanged.
- R7: In each frame the clock lane outputs the 7-bit pattern 1,1,0,0,0,1,1, and its first bit coincides with the first data bit.
- R8: From the first clk_i edge at which disable_i is high, all five outputs are low. They stay low while disable_i remains high, and pixel edges are ignored during that time.
- R9: After disable_i falls, the outputs stay low until the next active pixel edge, and the first frame then starts with R2 timing.
- R10: An inactive pixel-clock edge never starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_clk_i | input | 1 | Pixel clock, sampled as data |
| edge_sel_i | input | 1 | 0 selects rising active edge, 1 selects falling |
| disable_i | input | 1 | Park outputs low and clear state |
| pix_data_i | input | 28 | Parallel pixel word |
| lane_o | output | 4 | Serial data lanes, bit k is lane k |
| clk_lane_o | output | 1 | Generated clock lane |

## Verification
When the pixel period is exactly seven cycles, the detection of a new active edge lands in the same cycle as the reload at the end of the running frame. In that cycle the capture path and the frame-boundary load compete for the same word. A directed sequence places the second edge exactly seven cycles after the first. It then decodes the second frame bit by bit and expects the new word, not the stale one. Random runs with mostly seven-cycle periods exercise the same collision continuously under both polarities, and every lane bit is compared against a bench model.

// File: rtl/lvds7_pkg.sv
package lvds7_pkg;
  localparam int unsigned SLICE_W = 7;
  localparam int unsigned LANES   = 4;
  localparam int unsigned WORD_W  = SLICE_W * LANES;
  localparam logic [SLICE_W-1:0] CLK_PAT = 7'b1100011;
endpackage

// File: rtl/px_edge_det.sv
module px_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pix_clk_i,
  input  logic edge_sel_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pix_clk_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  // rising when sel=0, falling when sel=1
  assign edge_o = (sync_q[SYNC_STAGES-1] ^ prev_q) &
                  (sync_q[SYNC_STAGES-1] ^ edge_sel_i);
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl #(
  parameter int unsigned SLICE_W = 7,
  localparam int unsigned PH_W = $clog2(SLICE_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            edge_i,
  output logic            load_o,
  output logic            run_o,
  output logic [PH_W-1:0] phase_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(SLICE_W - 1);

  assign load_o = en_i & (run_o ? (phase_o == LAST) : edge_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      phase_o <= '0;
    end else if (!en_i) begin
      run_o   <= 1'b0;
      phase_o <= '0;
    end else if (load_o) begin
      run_o   <= 1'b1;
      phase_o <= '0;
    end else if (run_o) begin
      phase_o <= phase_o + 1'b1;
    end
  end
endmodule

// File: rtl/ser_lane.sv
module ser_lane #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         ser_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (clr_i)  sh_q <= '0;
    else if (load_i) sh_q <= data_i;
    else             sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign ser_o = sh_q[W-1];
endmodule

// File: rtl/lvds7_tx.sv
module lvds7_tx
  import lvds7_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_clk_i,
  input  logic              edge_sel_i,
  input  logic              disable_i,
  input  logic [WORD_W-1:0] pix_data_i,
  output logic [LANES-1:0]  lane_o,
  output logic              clk_lane_o
);
  localparam int unsigned PH_W = $clog2(SLICE_W);

  logic              edge_raw, edge_act, load, run;
  logic [PH_W-1:0]   phase;
  logic [WORD_W-1:0] hold_q, word_sel;

  px_edge_det #(.SYNC_STAGES(2)) u_edge (
    .clk_i, .rst_ni, .pix_clk_i, .edge_sel_i, .edge_o(edge_raw)
  );

  assign edge_act = edge_raw & ~disable_i;

  frame_ctrl #(.SLICE_W(SLICE_W)) u_ctrl (
    .clk_i, .rst_ni, .en_i(~disable_i), .edge_i(edge_act),
    .load_o(load), .run_o(run), .phase_o(phase)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hold_q <= '0;
    else if (edge_act) hold_q <= pix_data_i;
  end

  // a word arriving at a frame boundary bypasses the hold register
  assign word_sel = edge_act ? pix_data_i : hold_q;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      ser_lane #(.W(SLICE_W)) u_ser (
        .clk_i, .rst_ni, .clr_i(disable_i), .load_i(load),
        .data_i(word_sel[k*SLICE_W +: SLICE_W]), .ser_o(lane_o[k])
      );
    end
  endgenerate

  ser_lane #(.W(SLICE_W)) u_clk_lane (
    .clk_i, .rst_ni, .clr_i(disable_i), .load_i(load),
    .data_i(CLK_PAT), .ser_o(clk_lane_o)
  );
endmodule

// File: rtl/lvds7_tx_chk.sv
module lvds7_tx_chk
  import lvds7_pkg::*;
#(
  parameter int unsigned PH_W = $clog2(SLICE_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              disable_i,
  input logic [LANES-1:0]  lane_o,
  input logic              clk_lane_o,
  input logic              run_i,
  input logic [PH_W-1:0]   phase_i,
  input logic [WORD_W-1:0] hold_i
);
  localparam logic [PH_W-1:0] LAST = PH_W'(SLICE_W - 1);

  logic [LANES-1:0] msb_v;
  always_comb
    for (int k = 0; k < LANES; k++) msb_v[k] = hold_i[k*SLICE_W + SLICE_W - 1];

  p_dis_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> (lane_o == '0 && !clk_lane_o));

  p_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (lane_o == '0 && !clk_lane_o));

  p_period_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && phase_i == LAST && !disable_i) |=> (run_i && phase_i == '0));

  p_clk_pat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (clk_lane_o == CLK_PAT[SLICE_W-1 - int'(phase_i)]));

  p_first_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && phase_i == '0) |-> (lane_o == msb_v));
endmodule

bind lvds7_tx lvds7_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .disable_i(disable_i), .lane_o(lane_o),
  .clk_lane_o(clk_lane_o), .run_i(run), .phase_i(phase), .hold_i(hold_q)
);

// File: tb/sim_lvds7_tx.sv
`timescale 1ns/1ps
module sim_lvds7_tx;
  logic clk = 0, rst_n = 0;
  logic pclk = 0, sel = 0, dis = 0;
  logic [27:0] data = '0;
  logic [3:0] lane;
  logic clk_lane;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  lvds7_tx u0 (.clk_i(clk), .rst_ni(rst_n), .pix_clk_i(pclk), .edge_sel_i(sel),
               .disable_i(dis), .pix_data_i(data), .lane_o(lane), .clk_lane_o(clk_lane));

  // reference model state
  logic ms1 = 0, ms2 = 0, ms3 = 0, mrun = 0;
  int mph = 0;
  logic [6:0] msh [4];
  logic [6:0] mclk = '0;
  logic [27:0] mhold = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] slice(input logic [27:0] w, input int k);
    return w[k*7 +: 7];
  endfunction

  task automatic mdl_update();
    bit ed, ld;
    logic [27:0] w;
    ed = !dis && (sel ? (!ms2 && ms3) : (ms2 && !ms3));
    ld = !dis && (mrun ? (mph == 6) : ed);
    w  = ed ? data : mhold;
    ms3 = ms2; ms2 = ms1; ms1 = pclk;
    if (dis) begin
      mrun = 0; mph = 0; mclk = '0;
      for (int k = 0; k < 4; k++) msh[k] = '0;
    end else if (ld) begin
      mrun = 1; mph = 0; mclk = 7'b1100011;
      for (int k = 0; k < 4; k++) msh[k] = slice(w, k);
    end else begin
      if (mrun) mph++;
      mclk = mclk << 1;
      for (int k = 0; k < 4; k++) msh[k] = msh[k] << 1;
    end
    if (ed) mhold = data;
  endtask

  task automatic step();
    logic [3:0] exp_l;
    @(posedge clk);
    mdl_update();
    @(negedge clk);
    for (int k = 0; k < 4; k++) exp_l[k] = msh[k][6];
    if (dis)        chk(lane == 0 && !clk_lane, "R8 disabled outputs", {lane, clk_lane}, 0);
    else if (!mrun) chk(lane == 0 && !clk_lane, "R9/R10 idle outputs", {lane, clk_lane}, 0);
    else begin
      chk(lane == exp_l, "R3 lane bits", lane, exp_l);
      chk(clk_lane == mclk[6], "R7 clock lane", clk_lane, mclk[6]);
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pix_period(input int hi, input int lo);
    pclk = sel; data = $urandom; steps(lo);
    pclk = ~sel; steps(hi);
  endtask

  // collect one frame and compare with an independently expected word
  task automatic collect(input logic [27:0] w, input string tag);
    logic [6:0] got [4];
    for (int j = 0; j < 7; j++) begin
      for (int k = 0; k < 4; k++) got[k][6-j] = lane[k];
      step();
    end
    for (int k = 0; k < 4; k++) chk(got[k] == slice(w, k), tag, got[k], slice(w, k));
  endtask

  task automatic directed(input logic s);
    logic [27:0] a, b;
    a = $urandom; b = $urandom;
    sel = s; dis = 1; steps(3); dis = 0;
    pclk = s; data = a; steps(5);
    chk(lane == 0 && !clk_lane, "R10 inactive level idle", lane, 0);
    pclk = ~s; steps(2);
    chk(lane == 0, "R2 no output before third edge", lane, 0);
    step();
    chk(clk_lane == 1'b1, "R7 pattern starts with frame", clk_lane, 1);
    // second edge lands exactly on the frame boundary
    for (int j = 0; j < 7; j++) begin
      if (j == 0) begin pclk = s; data = b; end
      if (j == 4) pclk = ~s;
      step();
    end
    collect(b, "R5 boundary collision word");
    collect(b, "R6 resend without edge");
    dis = 1; step();
    chk(lane == 0 && !clk_lane, "R8 disable parks lanes", {lane, clk_lane}, 0);
    pclk = s; steps(3); pclk = ~s; steps(4);
    chk(lane == 0 && !clk_lane, "R8 edges ignored while disabled", {lane, clk_lane}, 0);
    dis = 0; steps(8);
    chk(lane == 0 && !clk_lane, "R9 idle after release", {lane, clk_lane}, 0);
    pclk = s; data = a; steps(3); pclk = ~s; steps(3);
    collect(a, "R9 first frame after release");
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 4; k++) msh[k] = '0;
    @(negedge clk); @(negedge clk);
    chk(lane == 0 && !clk_lane, "R1 reset outputs", {lane, clk_lane}, 0);
    rst_n = 1;
    steps(4);
    chk(lane == 0 && !clk_lane, "R1 idle after reset", {lane, clk_lane}, 0);
    directed(1'b0);
    directed(1'b1);
    for (int seg = 0; seg < 40; seg++) begin
      sel = $urandom_range(0, 1);
      for (int p = 0; p < 30; p++) begin
        int r;
        r = $urandom_range(0, 19);
        if (r == 0) begin dis = 1; steps($urandom_range(1, 5)); dis = 0; end
        if (r < 14)      pix_period(4, 3);               // R4 nominal period
        else if (r < 18) pix_period($urandom_range(3, 6), $urandom_range(3, 6)); // R6 late edges
        else             pix_period(20, 3);              // stalled pixel clock
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule